// File: doc/BRIEF.md
# Full-Bridge Pulse Filter and Underlap Stage

This block sits between a PWM modulator and the gate drivers of a single-phase full bridge. It takes the two raw leg levels, one per bridge leg, and produces four switch drives: left top, left bottom, right top and right bottom. For each leg it first removes pulses, high or low, that are shorter than a programmed minimum width. It then inserts a programmed underlap on each switching edge, so that the switch being turned on rises only after its partner has been off for that time.

All timing is counted in ticks of a time-base enable supplied from outside, which runs at 2048 times the carrier rate. This makes both programmed times fractions of a carrier period. After the timing stages, the block gates the outputs with an active-high run enable, with an emergency trip latch and with reset. It also reports whether the bridge is being driven.

Top module: `bridge_underlap_stage`

## Requirements
- R1: A leg level change that lasts fewer than `min_width` ticks, whether a high pulse on a low base or a low pulse on a high base, is removed: neither drive of that leg changes.
- R2: A leg level that stays stable for at least `min_width` ticks propagates. The filtered level changes at the clock edge that carries the max(`min_width`,1)-th tick after the change, and the leg drives react one clock after that. With `min_width` = 0, filtering is off.
- R3: Leg level 1 turns the top switch on and level 0 turns the bottom switch on; `leg_in` bit 0 is the left leg and bit 1 is the right leg. On a filtered edge, the switch that was on goes low one clock after the filtered change. The switch being turned on rises `underlap` ticks later, or on the same clock if `underlap` is 0.
- R4: The top and bottom drives of a leg are never high together.
- R5: A change of `min_width` or `underlap` while an edge is being filtered or its underlap is running does not alter that edge's timing.
- R6: While `tick` is low, no filtering or underlap time elapses and no pending edge reaches the drives.
- R7: With `run_en` low, all four drives are low in the same cycle, while filtering and underlap continue. Raising `run_en` again shows the current internal state at once.
- R8: When `trip_req` is high at a clock edge, all four drives and `trip_n` are low after that edge. They stay low after `trip_req` returns low.
- R9: The trip state clears only at the first clock edge with `rst_n` high after reset, and only if `trip_req` was low at the edge before. Otherwise it stays set.
- R10: While `rst_n` is low, all drives and `run_ok` are low. At the first tick after release, both bottom switches turn on and both top switches stay off.
- R11: `run_ok` is high exactly when `rst_n` is high, the block is not tripped and `run_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| tick | input | 1 | Time-base enable, 2048 per carrier period |
| leg_in | input | 2 | Raw leg levels, bit 0 left, bit 1 right |
| min_width | input | TW | Minimum pulse width in ticks |
| underlap | input | TW | Underlap time in ticks |
| run_en | input | 1 | Output enable, low forces drives off |
| trip_req | input | 1 | Emergency trip request, sampled |
| drv_lt | output | 1 | Left top switch drive |
| drv_lb | output | 1 | Left bottom switch drive |
| drv_rt | output | 1 | Right top switch drive |
| drv_rb | output | 1 | Right bottom switch drive |
| trip_n | output | 1 | Low while tripped |
| run_ok | output | 1 | High while the bridge is driven |

## Verification
With `tick` held high, a leg pulse applied for the edges E0 to E(W-1) moves the filtered level at edge E(P'-1), where P' = max(`min_width`,1). The turning-off switch falls after E(P'), and the turning-on switch rises after E(P'+`underlap`). The return edge follows W edges later. The bench turns this into a closed-form expectation for each sample index and compares both legs after every edge, sampling on the falling clock edge. Gating by `run_en` is checked in the same cycle. Trip and trip-clear results are checked after the one edge that samples them.

// File: rtl/bridge_dt_pkg.sv
package bridge_dt_pkg;
   localparam int NUM_LEGS = 2;

   typedef struct packed {
      logic top;
      logic bot;
   } sw_pair_t;
endpackage

// File: rtl/bdt_pulse_filter.sv
module bdt_pulse_filter #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          lvl_i,
   input  logic [TW-1:0] width_i,
   output logic          lvl_o
);
   logic [TW-1:0] run_cnt;
   logic [TW-1:0] width_q;
   logic          filt_q;

   generate
      if (TW < 2) begin : g_bad_tw
         $error("bdt_pulse_filter: TW must be at least 2");
      end
   endgenerate

   // width is captured only while idle, so an edge in flight keeps its length
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q  <= 1'b0;
         run_cnt <= '0;
         width_q <= '0;
      end else if (lvl_i == filt_q) begin
         run_cnt <= '0;
         width_q <= width_i;
      end else if (width_q == '0) begin
         filt_q  <= lvl_i;
         run_cnt <= '0;
      end else if (tick) begin
         if (run_cnt == width_q - TW'(1)) begin
            filt_q  <= lvl_i;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_cnt + TW'(1);
         end
      end
   end

   assign lvl_o = filt_q;

   // R1: with the input matching the filtered level, the level cannot move
   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i == filt_q) |=> $stable(filt_q));
endmodule

// File: rtl/bdt_underlap.sv
module bdt_underlap
   import bridge_dt_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          lvl_i,
   input  logic [TW-1:0] gap_i,
   output sw_pair_t      sw_o
);
   logic [TW-1:0] gap_cnt;
   logic          busy_q;
   logic          seen_q;
   logic          top_q;
   logic          bot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q  <= 1'b0;
         top_q   <= 1'b0;
         bot_q   <= 1'b0;
         busy_q  <= 1'b1;
         gap_cnt <= '0;
      end else if (lvl_i != seen_q) begin
         seen_q <= lvl_i;
         if (gap_i == '0) begin
            top_q  <= lvl_i;
            bot_q  <= ~lvl_i;
            busy_q <= 1'b0;
         end else begin
            top_q   <= 1'b0;
            bot_q   <= 1'b0;
            busy_q  <= 1'b1;
            gap_cnt <= gap_i;
         end
      end else if (busy_q && tick) begin
         if (gap_cnt <= TW'(1)) begin
            busy_q <= 1'b0;
            top_q  <= seen_q;
            bot_q  <= ~seen_q;
         end else begin
            gap_cnt <= gap_cnt - TW'(1);
         end
      end
   end

   assign sw_o.top = top_q;
   assign sw_o.bot = bot_q;

   // R4: never both switches of a leg on
   a_r4_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
      !(top_q && bot_q));
endmodule

// File: rtl/bdt_trip_latch.sv
module bdt_trip_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_req,
   output logic tripped
);
   logic req_s;
   logic trip_q;
   logic rst_d;

   // the latch is deliberately not cleared by reset assertion
   always_ff @(posedge clk) begin
      req_s <= trip_req;
      rst_d <= rst_n;
      if (rst_n && !rst_d) trip_q <= req_s;
      else                 trip_q <= trip_q | req_s;
   end

   assign tripped = trip_q | req_s;

   // R8: a sampled request trips the outputs after that edge
   a_r8_trip_now: assert property (@(posedge clk) disable iff (!rst_n)
      trip_req |=> tripped);

   // R9: once latched, only a reset release may clear it
   a_r9_trip_held: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_q && rst_d) |=> trip_q);
endmodule

// File: rtl/bridge_underlap_stage.sv
module bridge_underlap_stage
   import bridge_dt_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [1:0]    leg_in,
   input  logic [TW-1:0] min_width,
   input  logic [TW-1:0] underlap,
   input  logic          run_en,
   input  logic          trip_req,
   output logic          drv_lt,
   output logic          drv_lb,
   output logic          drv_rt,
   output logic          drv_rb,
   output logic          trip_n,
   output logic          run_ok
);
   localparam int LEGS = NUM_LEGS;

   sw_pair_t [LEGS-1:0] pairs;
   logic     [LEGS-1:0] filt_lvl;
   logic                tripped;

   generate
      if (LEGS != 2) begin : g_bad_legs
         $error("bridge_underlap_stage: a full bridge has two legs");
      end
      for (genvar g = 0; g < LEGS; g++) begin : g_leg
         bdt_pulse_filter #(.TW(TW)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .lvl_i   (leg_in[g]),
            .width_i (min_width),
            .lvl_o   (filt_lvl[g])
         );
         bdt_underlap #(.TW(TW)) u_gap (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .lvl_i (filt_lvl[g]),
            .gap_i (underlap),
            .sw_o  (pairs[g])
         );
      end
   endgenerate

   bdt_trip_latch u_trip (
      .clk      (clk),
      .rst_n    (rst_n),
      .trip_req (trip_req),
      .tripped  (tripped)
   );

   assign run_ok = rst_n & ~tripped & run_en;
   assign trip_n = ~tripped;
   assign drv_lt = pairs[0].top & run_ok;
   assign drv_lb = pairs[0].bot & run_ok;
   assign drv_rt = pairs[1].top & run_ok;
   assign drv_rb = pairs[1].bot & run_ok;

   // R7: a low enable leaves every drive off
   a_r7_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> !(drv_lt | drv_lb | drv_rt | drv_rb));
endmodule

// File: tb/bridge_underlap_stage_test.sv
module bridge_underlap_stage_test;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tick;
   logic [1:0]    leg_in;
   logic [TW-1:0] min_width;
   logic [TW-1:0] underlap;
   logic          run_en;
   logic          trip_req;
   logic          drv_lt, drv_lb, drv_rt, drv_rb, trip_n, run_ok;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bridge_underlap_stage #(.TW(TW)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .leg_in(leg_in),
      .min_width(min_width), .underlap(underlap), .run_en(run_en),
      .trip_req(trip_req), .drv_lt(drv_lt), .drv_lb(drv_lb),
      .drv_rt(drv_rt), .drv_rb(drv_rb), .trip_n(trip_n), .run_ok(run_ok)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0b expected=%0b (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // expected {top,bot} after edge k of a W-edge pulse at level pl
   function automatic logic [1:0] exp_pair(int k, int w, int p, int d, logic pl);
      int  pe = (p < 1) ? 1 : p;
      logic ps, bs;
      if (w < pe) begin
         ps = 1'b0; bs = 1'b1;
      end else begin
         ps = (k >= pe + d) && (k < w + pe);
         bs = !((k >= pe) && (k < w + pe + d));
      end
      return pl ? {ps, bs} : {bs, ps};
   endfunction

   task automatic settle(input logic [1:0] base);
      leg_in = base;
      repeat (30) @(negedge clk);
   endtask

   // R1 R2 R3 R4 R5: pulse trial on both legs
   task automatic trial(input int p, input int d, input int wl, input int wr,
                        input logic pl, input logic pr, input bit mid);
      int pe = (p < 1) ? 1 : p;
      int wm = (wl > wr) ? wl : wr;
      logic [1:0] el, er;
      min_width = TW'(p);
      underlap  = TW'(d);
      settle({~pr, ~pl});
      leg_in = {pr, pl};
      for (int k = 0; k <= wm + pe + d + 2; k++) begin
         @(negedge clk);
         el = exp_pair(k, wl, p, d, pl);
         er = exp_pair(k, wr, p, d, pr);
         if (mid) begin
            chk("R5", "left top",    drv_lt, el[1]);
            chk("R5", "left bottom", drv_lb, el[0]);
         end else begin
            chk((wl < pe) ? "R1" : "R3", "left top",     drv_lt, el[1]);
            chk((wl < pe) ? "R1" : "R2", "left bottom",  drv_lb, el[0]);
            chk((wr < pe) ? "R1" : "R3", "right top",    drv_rt, er[1]);
            chk((wr < pe) ? "R1" : "R2", "right bottom", drv_rb, er[0]);
         end
         chk("R4", "left overlap",  drv_lt & drv_lb, 1'b0);
         chk("R4", "right overlap", drv_rt & drv_rb, 1'b0);
         if (k == wl - 1) leg_in[0] = ~pl;
         if (k == wr - 1) leg_in[1] = ~pr;
         if (mid) begin
            if (k == 2)      min_width = TW'(1);
            if (k == 5)      min_width = TW'(p);
            if (k == pe + 1) underlap  = '0;
            if (k == pe + 4) underlap  = TW'(d);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      int r;
      r = $urandom(32'h5eed_0042);
      rst_n = 1'b0; tick = 1'b1; leg_in = 2'b00; min_width = '0;
      underlap = '0; run_en = 1'b1; trip_req = 1'b0;
      repeat (4) @(negedge clk);
      // R10: reset holds everything off
      chk("R10", "drives in reset", drv_lt | drv_lb | drv_rt | drv_rb, 1'b0);
      chk("R10", "run_ok in reset", run_ok, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "left bottom after release",  drv_lb, 1'b1);
      chk("R10", "right bottom after release", drv_rb, 1'b1);
      chk("R10", "tops after release", drv_lt | drv_rt, 1'b0);
      chk("R11", "run_ok running", run_ok, 1'b1);
      chk("R9",  "trip_n after clean reset", trip_n, 1'b1);

      // directed corners
      trial(4, 3, 3, 4, 1'b1, 1'b0, 0);   // R1 just below, R2 exactly at width
      trial(0, 0, 1, 2, 1'b0, 1'b1, 0);   // R2 filter off, R3 zero underlap
      trial(2, 9, 4, 12, 1'b1, 1'b1, 0);  // R3 pulse shorter than underlap
      trial(8, 6, 15, 15, 1'b1, 1'b1, 1); // R5 settings changed mid edge

      // random trials
      for (int t = 0; t < 40; t++) begin
         trial(int'($urandom_range(0, 12)), int'($urandom_range(0, 10)),
               int'($urandom_range(1, 20)), int'($urandom_range(1, 20)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0);
      end

      // R6: no tick, no progress
      min_width = TW'(3); underlap = TW'(1);
      settle(2'b00);
      tick = 1'b0;
      leg_in = 2'b11;
      repeat (10) begin
         @(negedge clk);
         chk("R6", "left bottom frozen",  drv_lb, 1'b1);
         chk("R6", "right top frozen",    drv_rt, 1'b0);
      end
      leg_in = 2'b00;
      @(negedge clk);
      tick = 1'b1;

      // R7: enable gating, generation continues underneath
      min_width = TW'(2); underlap = TW'(3);
      settle(2'b00);
      run_en = 1'b0;
      #1;
      chk("R7", "drives off at once", drv_lt | drv_lb | drv_rt | drv_rb, 1'b0);
      chk("R11", "run_ok with enable low", run_ok, 1'b0);
      leg_in = 2'b01;
      repeat (12) begin
         @(negedge clk);
         chk("R7", "drives held off", drv_lt | drv_lb | drv_rt | drv_rb, 1'b0);
      end
      run_en = 1'b1;
      #1;
      chk("R7", "left top resumes",    drv_lt, 1'b1);
      chk("R7", "left bottom resumes", drv_lb, 1'b0);
      chk("R7", "right bottom resumes", drv_rb, 1'b1);

      // R8: trip
      @(negedge clk);
      trip_req = 1'b1;
      @(negedge clk);
      chk("R8", "drives after trip", drv_lt | drv_lb | drv_rt | drv_rb, 1'b0);
      chk("R8", "trip_n after trip", trip_n, 1'b0);
      chk("R11", "run_ok when tripped", run_ok, 1'b0);
      trip_req = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8", "trip latched", trip_n, 1'b0);
      chk("R8", "drives stay off", drv_lt | drv_lb | drv_rt | drv_rb, 1'b0);

      // R9: clear on release with request low
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "trip cleared by release", trip_n, 1'b1);
      chk("R9", "run_ok after clear", run_ok, 1'b1);

      // R9: request high through release keeps the trip
      trip_req = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      trip_req = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", "trip kept over release", trip_n, 1'b0);
      chk("R9", "drives kept off", drv_lt | drv_lb | drv_rt | drv_rb, 1'b0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "trip cleared at last", trip_n, 1'b1);

      report();
   end
endmodule